// File: doc/BRIEF.md
# Upper-Level Translation Paging Cache

This block holds the combined result of the top two levels of a four-level page-table walk, so a walker can skip both levels when a later translation falls in the same 1 GiB region. Each entry is tagged by linear-address bits 47:30. An entry records the physical base of the page directory named by the second-level entry, together with one merged set of permission and cache-control bits.

A lookup port takes a 48-bit linear address. In the same cycle it returns a hit flag, the stored base and the stored attributes. A fill port takes the raw permission bits of both levels, and the merge is done when the entry is written. Two maintenance inputs remove entries: one removes the entry matching an address, the other clears the whole cache. An entry never changes on its own, because page-table memory is not watched. Software must invalidate after it edits those tables.

The cache is fully associative with 8 slots. A refill of a tag that is already present rewrites that slot in place. A new tag takes the lowest-numbered free slot. When every slot is in use, a round-robin pointer picks the slot to evict.

Top module: `upl_xlat_cache`

## Requirements
- R1: A lookup hits only when linear-address bits 47:30 equal the tag of a valid entry. Bits 29:0 have no effect, and no lookup hits after reset.
- R2: On a hit, `lk_base` returns the page-directory base given at fill time, in the same cycle as the lookup address, with no clock edge between them.
- R3: The stored write bit is the AND of the two levels' write bits. The stored user bit is the AND of the two levels' user bits.
- R4: The stored execute-disable bit is the OR of the two levels' execute-disable bits.
- R5: The stored cache-disable and write-through bits are taken from the second level only. The first-level cache-control inputs have no effect on any lookup result.
- R6: A stored entry returns the same base and attributes on every later lookup, however many cycles pass, until it is invalidated, flushed, evicted or refilled.
- R7: A fill whose tag equals a valid entry's tag rewrites that slot and does not use a second slot.
- R8: A fill of a new tag uses the lowest-numbered free slot. When no slot is free, it evicts the slot named by a round-robin pointer. The pointer is 0 after reset and steps by one, wrapping after slot 7, only on such an eviction. A flush does not move the pointer.
- R9: An invalidate-by-address removes the entry whose tag equals bits 47:30 of `inv_addr` at the next clock edge. All other entries are kept.
- R10: A flush clears every entry at the next clock edge.
- R11: A fill presented in the same cycle as a flush or an invalidate is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | 48 | Lookup linear address |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_base | output | 40 | Page-directory physical base (address bits 51:12) |
| lk_wr | output | 1 | Merged write permission |
| lk_usr | output | 1 | Merged user permission |
| lk_nx | output | 1 | Merged execute-disable |
| lk_pcd | output | 1 | Cache-disable from the second level |
| lk_pwt | output | 1 | Write-through from the second level |
| fill_en | input | 1 | Write a new entry at this clock edge |
| fill_addr | input | 48 | Linear address that supplies the tag |
| fill_base | input | 40 | Page-directory base from the second level |
| fill_top_wr | input | 1 | First-level write bit |
| fill_top_usr | input | 1 | First-level user bit |
| fill_top_nx | input | 1 | First-level execute-disable bit |
| fill_top_pcd | input | 1 | First-level cache-disable bit (not stored) |
| fill_top_pwt | input | 1 | First-level write-through bit (not stored) |
| fill_nxt_wr | input | 1 | Second-level write bit |
| fill_nxt_usr | input | 1 | Second-level user bit |
| fill_nxt_nx | input | 1 | Second-level execute-disable bit |
| fill_nxt_pcd | input | 1 | Second-level cache-disable bit |
| fill_nxt_pwt | input | 1 | Second-level write-through bit |
| inv_en | input | 1 | Invalidate the entry matching inv_addr |
| inv_addr | input | 48 | Address whose bits 47:30 select the entry |
| flush | input | 1 | Clear all entries |

## Verification
Six table vectors use different pairs of first- and second-level bits, chosen so that swapping the AND and OR merges, or taking cache control from the wrong level, changes at least one output. Each lookup sets different low address bits, and neighbouring tags differ only in bit 30, which separates a correct tag slice from one shifted by one bit. A directed sequence fills past capacity, refills a present tag, invalidates a middle slot and then fills again. The pattern of hits and misses after that sequence tells an in-place refill from a duplicate, a free slot from the pointer's slot, and a pointer that steps on every fill from one that steps only on evictions. Fills issued in the same cycle as a flush or an invalidate show whether maintenance wins.

// File: rtl/upc_pkg.sv
// Shared types for the upper-level translation cache.
// Assumes the attribute set is fixed by the paging format, so it is kept out of the parameters.
package upc_pkg;

    // Permission bits that take part in the two-level merge.
    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
    } upc_perm_t;

    // Attribute set stored with each entry.
    typedef struct packed {
        logic wr;
        logic usr;
        logic nx;
        logic pcd;
        logic pwt;
    } upc_attr_t;

endpackage

// File: rtl/upc_merge.sv
// Merges the permission bits of two table levels into the attribute set stored in one entry.
// Assumes: plain combinational logic. A permission survives only if both levels grant it,
// execute-disable holds if either level sets it, and cache control comes from the lower level.
module upc_merge
    import upc_pkg::*;
(
    input  upc_perm_t top_p,
    input  upc_attr_t nxt_a,
    output upc_attr_t merged
);

    // Build the stored attribute set from both levels.
    always_comb begin
        merged.wr  = top_p.wr  & nxt_a.wr;
        merged.usr = top_p.usr & nxt_a.usr;
        merged.nx  = top_p.nx  | nxt_a.nx;
        merged.pcd = nxt_a.pcd;
        merged.pwt = nxt_a.pwt;
    end

endmodule

// File: rtl/upc_match.sv
// Compares one search key with every stored tag and returns one match bit per slot.
// Assumes an invalid slot never matches. Slot contents are supplied by the caller.
module upc_match #(
    parameter int N     = 8,
    parameter int TAG_W = 18
) (
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [N-1:0]            valid,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit_vec
);

    // One equality comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

endmodule

// File: rtl/upc_victim.sv
// Chooses the slot that a fill writes: the matching slot, then the lowest free slot,
// then the round-robin pointer. The pointer steps only when it is actually used.
// Assumes at most one bit of same_vec is set.
module upc_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     same_vec,
    input  logic             fire,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] same_idx;
    logic             free_any;
    logic             use_rr;

    // Encode the lowest free slot and the matching slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        same_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (same_vec[i]) begin
                same_idx = IDX_W'(i);
            end
        end
    end

    // Choose by priority: refill in place, then free slot, then the pointer.
    always_comb begin
        use_rr = 1'b0;
        if (|same_vec) begin
            slot = same_idx;
        end else if (free_any) begin
            slot = free_idx;
        end else begin
            slot   = ptr_q;
            use_rr = 1'b1;
        end
    end

    // Step the round-robin pointer after each eviction, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fire && use_rr) begin
            ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/upl_xlat_cache.sv
// Fully associative cache of merged top-two-level walk results, tagged by the upper
// linear-address bits. Lookup is combinational. Fill, invalidate and flush take effect at
// the clock edge, and a fill is dropped when maintenance is requested in the same cycle.
// Assumes the walker never relies on this block to notice table edits in memory.
module upl_xlat_cache
    import upc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LA_W    = 48,
    parameter int TAG_LSB = 30,
    parameter int PA_W    = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LA_W-1:0] lk_addr,
    output logic            lk_hit,
    output logic [PA_W-1:0] lk_base,
    output logic            lk_wr,
    output logic            lk_usr,
    output logic            lk_nx,
    output logic            lk_pcd,
    output logic            lk_pwt,
    input  logic            fill_en,
    input  logic [LA_W-1:0] fill_addr,
    input  logic [PA_W-1:0] fill_base,
    input  logic            fill_top_wr,
    input  logic            fill_top_usr,
    input  logic            fill_top_nx,
    input  logic            fill_top_pcd,
    input  logic            fill_top_pwt,
    input  logic            fill_nxt_wr,
    input  logic            fill_nxt_usr,
    input  logic            fill_nxt_nx,
    input  logic            fill_nxt_pcd,
    input  logic            fill_nxt_pwt,
    input  logic            inv_en,
    input  logic [LA_W-1:0] inv_addr,
    input  logic            flush
);

    localparam int TAG_W = LA_W - TAG_LSB;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][PA_W-1:0]  base_q;
    upc_attr_t                     attr_q [ENTRIES];

    logic [TAG_W-1:0]   lk_tag, fill_tag, inv_tag;
    logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
    logic [IDX_W-1:0]   fill_slot;
    logic               fill_go;
    upc_perm_t          top_p;
    upc_attr_t          nxt_a, new_a, lk_a;
    logic               unused_bits;

    assign lk_tag   = lk_addr[LA_W-1:TAG_LSB];
    assign fill_tag = fill_addr[LA_W-1:TAG_LSB];
    assign inv_tag  = inv_addr[LA_W-1:TAG_LSB];
    assign fill_go  = fill_en && !flush && !inv_en;

    // Collect the inputs that the block deliberately ignores.
    assign unused_bits = ^{lk_addr[TAG_LSB-1:0], fill_addr[TAG_LSB-1:0],
                           inv_addr[TAG_LSB-1:0], fill_top_pcd, fill_top_pwt};

    // Gather the fill-side attribute bits of both levels.
    assign top_p = '{wr: fill_top_wr, usr: fill_top_usr, nx: fill_top_nx};
    assign nxt_a = '{wr: fill_nxt_wr, usr: fill_nxt_usr, nx: fill_nxt_nx,
                     pcd: fill_nxt_pcd, pwt: fill_nxt_pwt};

    upc_merge u_merge (
        .top_p  (top_p),
        .nxt_a  (nxt_a),
        .merged (new_a)
    );

    upc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
        .tags (tag_q), .valid (valid_q), .key (lk_tag), .hit_vec (lk_match)
    );

    upc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_fill_match (
        .tags (tag_q), .valid (valid_q), .key (fill_tag), .hit_vec (fill_match)
    );

    upc_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_inv_match (
        .tags (tag_q), .valid (valid_q), .key (inv_tag), .hit_vec (inv_match)
    );

    upc_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid_q),
        .same_vec (fill_match),
        .fire     (fill_go),
        .slot     (fill_slot)
    );

    // Valid bits: reset and flush clear all, invalidate clears matches, fill sets its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (inv_en) begin
            valid_q <= valid_q & ~inv_match;
        end else if (fill_go) begin
            valid_q[fill_slot] <= 1'b1;
        end
    end

    // Entry payload: written only by an accepted fill, never refreshed from memory.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[fill_slot]  <= fill_tag;
            base_q[fill_slot] <= fill_base;
            attr_q[fill_slot] <= new_a;
        end
    end

    // Combinational read-out: OR together the payload of the one matching slot.
    always_comb begin
        lk_base = '0;
        lk_a    = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_base = lk_base | base_q[i];
                lk_a    = upc_attr_t'(lk_a | attr_q[i]);
            end
        end
    end

    assign lk_hit = |lk_match;
    assign lk_wr  = lk_a.wr;
    assign lk_usr = lk_a.usr;
    assign lk_nx  = lk_a.nx;
    assign lk_pcd = lk_a.pcd;
    assign lk_pwt = lk_a.pwt;

endmodule

// File: rtl/upc_checker.sv
// Temporal checks on the upper-level translation cache, attached through bind.
// Assumes it sees the valid vector and the lookup match vector of the cache.
module upc_checker #(
    parameter int N     = 8,
    parameter int TAG_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             inv_en,
    input logic [TAG_W-1:0] inv_tag,
    input logic             fill_en,
    input logic [TAG_W-1:0] lk_tag,
    input logic             lk_hit,
    input logic [N-1:0]     valid,
    input logic [N-1:0]     lk_match
);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid == '0));

    a_r9_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !flush) |=> !(lk_hit && (lk_tag == $past(inv_tag))));

    a_r11_fill_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && (flush || inv_en)) |=> ($countones(valid) <= $countones($past(valid))));

    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !inv_en && !flush) |=> $stable(valid));

    a_r8_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_en && !flush) |=> (valid != '0));

endmodule

bind upl_xlat_cache upc_checker #(.N(ENTRIES), .TAG_W(TAG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .inv_en   (inv_en),
    .inv_tag  (inv_tag),
    .fill_en  (fill_en),
    .lk_tag   (lk_tag),
    .lk_hit   (lk_hit),
    .valid    (valid_q),
    .lk_match (lk_match)
);

// File: tb/tb_upl_xlat_cache.sv
// Self-checking bench: a table of fill/lookup vectors, then directed replacement and maintenance tests.
// Attribute vectors are packed {wr, usr, nx, pcd, pwt}.
module tb_upl_xlat_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        lk_hit;
    logic [39:0] lk_base;
    logic        lk_wr, lk_usr, lk_nx, lk_pcd, lk_pwt;
    logic        fill_en = 1'b0;
    logic [47:0] fill_addr = '0;
    logic [39:0] fill_base = '0;
    logic [4:0]  f_top = '0;
    logic [4:0]  f_nxt = '0;
    logic        inv_en = 1'b0;
    logic [47:0] inv_addr = '0;
    logic        flush = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    upl_xlat_cache dut (
        .clk (clk), .rst_n (rst_n), .lk_addr (lk_addr), .lk_hit (lk_hit), .lk_base (lk_base),
        .lk_wr (lk_wr), .lk_usr (lk_usr), .lk_nx (lk_nx), .lk_pcd (lk_pcd), .lk_pwt (lk_pwt),
        .fill_en (fill_en), .fill_addr (fill_addr), .fill_base (fill_base),
        .fill_top_wr (f_top[4]), .fill_top_usr (f_top[3]), .fill_top_nx (f_top[2]),
        .fill_top_pcd (f_top[1]), .fill_top_pwt (f_top[0]),
        .fill_nxt_wr (f_nxt[4]), .fill_nxt_usr (f_nxt[3]), .fill_nxt_nx (f_nxt[2]),
        .fill_nxt_pcd (f_nxt[1]), .fill_nxt_pwt (f_nxt[0]),
        .inv_en (inv_en), .inv_addr (inv_addr), .flush (flush)
    );

    // {tag[17:0], base[39:0], top attrs[4:0], next attrs[4:0]}
    localparam logic [67:0] VEC [6] = '{
        {18'h00001, 40'h00_0000_1000, 5'b11000, 5'b11011},
        {18'h3FFFF, 40'hFF_FFFF_FFFF, 5'b01111, 5'b10100},
        {18'h20000, 40'h80_0000_0001, 5'b10101, 5'b01010},
        {18'h15555, 40'h55_5555_5555, 5'b11100, 5'b11000},
        {18'h0AAAA, 40'h2A_AAAA_AAAA, 5'b00011, 5'b00101},
        {18'h12345, 40'h01_2345_6789, 5'b11111, 5'b11111}
    };

    function automatic logic [4:0] exp_attr(input logic [4:0] t, input logic [4:0] n);
        return {t[4] & n[4], t[3] & n[3], t[2] | n[2], n[1], n[0]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic do_fill(input logic [17:0] tag, input logic [39:0] base,
                           input logic [4:0] t, input logic [4:0] n);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = {tag, 30'h2BAD_F00D}; fill_base = base;
        f_top = t; f_nxt = n;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inv(input logic [17:0] tag);
        @(negedge clk);
        inv_en = 1'b1; inv_addr = {tag, 30'h1357_9BDF};
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic look(input logic [17:0] tag, input logic [29:0] low);
        lk_addr = {tag, low};
        #1;
    endtask

    task automatic hit_is(input string req, input logic [17:0] tag, input logic exp);
        look(tag, 30'h0ABC_DEF0);
        check(req, 64'(lk_hit), 64'(exp));
    endtask

    // Watchdog: a hung run is one failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: nothing hits after reset
        hit_is("R1 reset miss", 18'h00000, 1'b0);
        hit_is("R1 reset miss", VEC[0][67:50], 1'b0);

        // Table walk: fill every vector, then look each one up
        for (int i = 0; i < 6; i++) do_fill(VEC[i][67:50], VEC[i][49:10], VEC[i][9:5], VEC[i][4:0]);
        for (int i = 0; i < 6; i++) begin
            logic [4:0] ea;
            ea = exp_attr(VEC[i][9:5], VEC[i][4:0]);
            @(negedge clk);
            look(VEC[i][67:50], 30'(i * 32'h0123_4567));
            check("R1 hit", 64'(lk_hit), 64'd1);
            check("R2 base", 64'(lk_base), 64'(VEC[i][49:10]));
            check("R3 wr/usr and", 64'({lk_wr, lk_usr}), 64'(ea[4:3]));
            check("R4 nx or", 64'(lk_nx), 64'(ea[2]));
            check("R5 pcd/pwt", 64'({lk_pcd, lk_pwt}), 64'(ea[1:0]));
        end

        // R1: neighbour tag differing in bit 30 misses; R2: bits 29:0 ignored
        hit_is("R1 bit30 neighbour", 18'h00000, 1'b0);
        look(VEC[5][67:50], 30'h3FFF_FFFF);
        check("R2 low bits ignored", 64'(lk_base), 64'(VEC[5][49:10]));

        // R6: entry unchanged after many idle cycles
        repeat (20) @(negedge clk);
        look(VEC[0][67:50], 30'h0);
        check("R6 stale base", 64'(lk_base), 64'(VEC[0][49:10]));
        check("R6 stale attrs", 64'({lk_wr, lk_usr, lk_nx, lk_pcd, lk_pwt}), 64'(5'b11011));

        // R7: refill of a present tag rewrites in place
        do_fill(VEC[0][67:50], 40'h12_3456_7000, 5'b11111, 5'b00000);
        look(VEC[0][67:50], 30'h5);
        check("R7 new base", 64'(lk_base), 64'h12_3456_7000);
        check("R7 new attrs", 64'({lk_wr, lk_usr, lk_nx, lk_pcd, lk_pwt}), 64'(5'b00100));
        do_fill(18'h00AA0, 40'h1, 5'b0, 5'b0);
        do_fill(18'h00AA1, 40'h2, 5'b0, 5'b0);
        do_fill(18'h00AA2, 40'h3, 5'b0, 5'b0);
        hit_is("R7 slot0 evicted", VEC[0][67:50], 1'b0);
        hit_is("R7 no duplicate", VEC[1][67:50], 1'b1);

        // R10: flush empties the cache
        @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
        hit_is("R10 flush", VEC[1][67:50], 1'b0);
        hit_is("R10 flush", 18'h00AA2, 1'b0);

        // R8: round-robin after reset
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) do_fill(18'h100 + 18'(i), 40'(i), 5'b0, 5'b0);
        do_fill(18'h108, 40'h8, 5'b0, 5'b0);
        hit_is("R8 evict slot0", 18'h100, 1'b0);
        hit_is("R8 keep slot1", 18'h101, 1'b1);
        hit_is("R8 new in", 18'h108, 1'b1);
        do_fill(18'h109, 40'h9, 5'b0, 5'b0);
        hit_is("R8 evict slot1", 18'h101, 1'b0);
        hit_is("R8 keep slot2", 18'h102, 1'b1);

        // R9: invalidate one, free slot reused before the pointer
        do_inv(18'h105);
        hit_is("R9 removed", 18'h105, 1'b0);
        hit_is("R9 neighbour kept", 18'h104, 1'b1);
        hit_is("R9 neighbour kept", 18'h106, 1'b1);
        do_fill(18'h10A, 40'hA, 5'b0, 5'b0);
        hit_is("R8 free slot first", 18'h102, 1'b1);
        hit_is("R8 free slot first", 18'h10A, 1'b1);
        do_fill(18'h10B, 40'hB, 5'b0, 5'b0);
        hit_is("R8 pointer slot2", 18'h102, 1'b0);
        hit_is("R8 pointer slot2", 18'h103, 1'b1);

        // R11: fill together with invalidate or flush is dropped
        @(negedge clk);
        fill_en = 1'b1; fill_addr = {18'h10C, 30'h0}; fill_base = 40'hC;
        inv_en = 1'b1; inv_addr = {18'h103, 30'h0};
        @(negedge clk);
        fill_en = 1'b0; inv_en = 1'b0;
        hit_is("R11 fill vs inv", 18'h10C, 1'b0);
        hit_is("R9 inv applied", 18'h103, 1'b0);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = {18'h10D, 30'h0}; flush = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
        hit_is("R11 fill vs flush", 18'h10D, 1'b0);
        hit_is("R10 flush all", 18'h10A, 1'b0);

        finish_run();
    end

endmodule